// File: doc/BRIEF.md
# Timer Output Compare Unit

The unit watches one of two free-running 16-bit timers and compares the selected count with a programmable compare value. When the two become equal, the unit acts according to a 4-bit mode code. It can toggle an output pin, drive the pin to a fixed level after setting it to the opposite level, or only raise an event flag. It can also request a timer reset and, on the instance built as the second unit, start an analog-to-digital conversion.

The flag stays set until software clears it. A timer that stalls on the compare value counts as one match, not one match per clock. The pin is registered and comes with an output-enable. When the enable is low, the pin can be handed back to general-purpose I/O logic outside the unit. Every output is registered, so each one responds on the clock edge that samples the causing inputs.

Top module: `ocmp_unit`

## Requirements
- R1: Mode 4'b0010 inverts the pin on every match and sets the flag.
- R2: Mode 4'b1000 sets the pin to 0 on mode entry and sets it to 1 on a match, which also sets the flag.
- R3: Mode 4'b1001 sets the pin to 1 on mode entry and sets it to 0 on a match, which also sets the flag.
- R4: Mode 4'b1010 only sets the flag on a match. The pin stays at 0, and the output-enable is low.
- R5: Mode 4'b1011 sets the flag on a match and emits a one-cycle timer-reset pulse. When parameter UNIT_IDX is 1, a one-cycle conversion-start pulse is emitted in the same cycle. When UNIT_IDX is 0, the conversion-start output stays 0.
- R6: Mode 4'b0000 forces the pin to 0 and the output-enable to 0, clears the flag, and emits no pulses. Reset produces the same state.
- R7: All other codes (capture codes 0001, 0011 to 0111, and 11xx) take no compare action: no flag is set and no pulse is emitted.
- R8: A match needs the selected timer to equal the compare value. tmr_sel=0 selects tmr_a and tmr_sel=1 selects tmr_b.
- R9: The flag stays set until flag_clr is high in a cycle without a new match. A match in the same cycle as flag_clr leaves the flag set.
- R10: Only the first cycle of equality is a match. Equality that lasts over later cycles does not act again.
- R11: The output-enable is 1 exactly when the mode is 0010, 1000, 1001 or 1011.
- R12: A cycle whose mode differs from the previous cycle's mode is a mode-entry cycle. In that cycle the pin is initialised, and no match action takes place.
- R13: All outputs are registered. A cause seen at one clock edge appears on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Compare mode code |
| cmp_val | input | 16 | Compare value |
| tmr_a | input | 16 | First timer count |
| tmr_b | input | 16 | Second timer count |
| tmr_sel | input | 1 | Timer select: 0 selects tmr_a, 1 selects tmr_b |
| flag_clr | input | 1 | Software clear of the match flag |
| pin_o | output | 1 | Compare output pin level |
| pin_oe | output | 1 | Output-enable for the pin |
| flag_o | output | 1 | Sticky match flag |
| tmr_rst_o | output | 1 | One-cycle timer-reset request |
| adc_go_o | output | 1 | One-cycle conversion-start request |

## Verification
The assertions assume that the inputs are settled at each rising edge and that reset is held for at least one edge before the first checked cycle. Their past-value checks start only after one clock with reset low. The stimulus meets these assumptions by changing every input on the falling edge and by asserting reset from time zero for several cycles. Within those limits, the sweep covers every mode code and both timer selects. It also makes the timer stall on the compare value and pulses the clear at times that sometimes fall on a match.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] OM_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] OM_TOGGLE  = 4'b0010;
  localparam logic [MODE_W-1:0] OM_SET     = 4'b1000;
  localparam logic [MODE_W-1:0] OM_CLR     = 4'b1001;
  localparam logic [MODE_W-1:0] OM_FLAG    = 4'b1010;
  localparam logic [MODE_W-1:0] OM_SPECIAL = 4'b1011;

  // Modes that act on a compare match.
  function automatic logic is_cmp_mode(input logic [MODE_W-1:0] m);
    return (m == OM_TOGGLE) || (m == OM_SET) || (m == OM_CLR) ||
           (m == OM_FLAG) || (m == OM_SPECIAL);
  endfunction

  // Modes in which the unit owns the pin.
  function automatic logic is_drive_mode(input logic [MODE_W-1:0] m);
    return (m == OM_TOGGLE) || (m == OM_SET) || (m == OM_CLR) ||
           (m == OM_SPECIAL);
  endfunction
endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          tmr_sel,
  input  logic [TW-1:0] cmp_val,
  output logic          first_eq
);
  logic [TW-1:0] tsel;
  logic          eq;
  logic          eq_q;

  assign tsel     = tmr_sel ? tmr_b : tmr_a;
  assign eq       = (tsel == cmp_val);
  assign first_eq = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  // R10: equality that persists across edges yields a single first cycle.
  p_single_first_r10: assert property (@(posedge clk) disable iff (rst)
    first_eq |=> !first_eq);
endmodule

// File: rtl/ocmp_mode_track.sv
module ocmp_mode_track
  import ocmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  output logic              entry,
  output logic              cmp_mode,
  output logic              drive_mode
);
  logic [MODE_W-1:0] mode_q;

  assign entry      = (mode != mode_q);
  assign cmp_mode   = is_cmp_mode(mode);
  assign drive_mode = is_drive_mode(mode);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= OM_OFF;
    else     mode_q <= mode;
  end
endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
  import ocmp_pkg::*;
#(
  parameter int UNIT_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              entry,
  input  logic              cmp_mode,
  input  logic              drive_mode,
  input  logic              first_eq,
  input  logic              flag_clr,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              flag_o,
  output logic              tmr_rst_o,
  output logic              adc_go_o
);
  logic hit;
  logic special_hit;
  logic live_q;

  assign hit         = first_eq & ~entry & cmp_mode;
  assign special_hit = hit & (mode == OM_SPECIAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o     <= 1'b0;
      pin_oe    <= 1'b0;
      flag_o    <= 1'b0;
      tmr_rst_o <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      live_q    <= 1'b1;
      pin_oe    <= drive_mode;
      tmr_rst_o <= special_hit;
      if (mode == OM_OFF) begin
        pin_o  <= 1'b0;
        flag_o <= 1'b0;
      end else begin
        if (entry) begin
          pin_o <= (mode == OM_CLR);
        end else if (hit) begin
          case (mode)
            OM_TOGGLE: pin_o <= ~pin_o;
            OM_SET:    pin_o <= 1'b1;
            OM_CLR:    pin_o <= 1'b0;
            default:   pin_o <= pin_o;
          endcase
        end
        if (hit)           flag_o <= 1'b1;
        else if (flag_clr) flag_o <= 1'b0;
      end
    end
  end

  generate
    if (UNIT_IDX == 1) begin : g_adc
      always_ff @(posedge clk) begin
        if (rst) adc_go_o <= 1'b0;
        else     adc_go_o <= special_hit;
      end
    end else begin : g_no_adc
      assign adc_go_o = 1'b0;
    end
  endgenerate

  // R5: the timer-reset request never lasts two cycles.
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_o |=> !tmr_rst_o);
  // R5: a conversion start only accompanies a timer-reset request.
  p_adc_with_rst_r5: assert property (@(posedge clk) disable iff (rst)
    adc_go_o |-> tmr_rst_o);
  // R5/R9: a special-event pulse always comes with the flag raised.
  p_rst_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
    tmr_rst_o |-> flag_o);
  // R9: flag holds while no clear and the unit is enabled.
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(flag_o) && !$past(flag_clr) && $past(mode) != OM_OFF) |-> flag_o);
  // R1: pin moves only on entry, match, or disable.
  p_pin_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (live_q && !$past(entry) && !$past(first_eq) && $past(mode) != OM_OFF) |-> $stable(pin_o));
  // R11: released pin is never driven high by the non-driving flag mode.
  p_flag_mode_low_r4: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(mode) == OM_FLAG) |-> (!pin_oe && !pin_o));
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int TW       = 16,
  parameter int UNIT_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [TW-1:0]     cmp_val,
  input  logic [TW-1:0]     tmr_a,
  input  logic [TW-1:0]     tmr_b,
  input  logic              tmr_sel,
  input  logic              flag_clr,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              flag_o,
  output logic              tmr_rst_o,
  output logic              adc_go_o
);
  logic first_eq;
  logic entry;
  logic cmp_mode;
  logic drive_mode;

  ocmp_match #(.TW(TW)) u_match (
    .clk      (clk),
    .rst      (rst),
    .tmr_a    (tmr_a),
    .tmr_b    (tmr_b),
    .tmr_sel  (tmr_sel),
    .cmp_val  (cmp_val),
    .first_eq (first_eq)
  );

  ocmp_mode_track u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .entry      (entry),
    .cmp_mode   (cmp_mode),
    .drive_mode (drive_mode)
  );

  ocmp_action #(.UNIT_IDX(UNIT_IDX)) u_action (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .entry      (entry),
    .cmp_mode   (cmp_mode),
    .drive_mode (drive_mode),
    .first_eq   (first_eq),
    .flag_clr   (flag_clr),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe),
    .flag_o     (flag_o),
    .tmr_rst_o  (tmr_rst_o),
    .adc_go_o   (adc_go_o)
  );

  // R6: a disabled unit leaves the pin released one edge later.
  p_off_release_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_OFF) |=> (!pin_oe && !pin_o && !flag_o));
endmodule

// File: tb/ocmp_unit_bench.sv
module ocmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    mode = 4'd0;
  logic [TW-1:0] cmp_val = '0;
  logic [TW-1:0] tmr_a = '0;
  logic [TW-1:0] tmr_b = '0;
  logic          tmr_sel = 1'b0;
  logic          flag_clr = 1'b0;
  logic pin1, oe1, flag1, trst1, adc1;
  logic pin0, oe0, flag0, trst0, adc0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_unit #(.TW(TW), .UNIT_IDX(1)) u_ocmp_unit (
    .clk(clk), .rst(rst), .mode(mode), .cmp_val(cmp_val), .tmr_a(tmr_a),
    .tmr_b(tmr_b), .tmr_sel(tmr_sel), .flag_clr(flag_clr), .pin_o(pin1),
    .pin_oe(oe1), .flag_o(flag1), .tmr_rst_o(trst1), .adc_go_o(adc1));

  ocmp_unit #(.TW(TW), .UNIT_IDX(0)) u_ocmp_unit_idx0 (
    .clk(clk), .rst(rst), .mode(mode), .cmp_val(cmp_val), .tmr_a(tmr_a),
    .tmr_b(tmr_b), .tmr_sel(tmr_sel), .flag_clr(flag_clr), .pin_o(pin0),
    .pin_oe(oe0), .flag_o(flag0), .tmr_rst_o(trst0), .adc_go_o(adc0));

  // model state, derived from the requirements
  logic [3:0] m_mode_q;
  logic m_eqq, m_pin, m_oe, m_flag, m_trst;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t mode=%b actual=%b expected=%b", tag, $time, mode, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [3:0] m);
    case (m)
      4'b0010: return "R1";
      4'b1000: return "R2";
      4'b1001: return "R3";
      4'b1010: return "R4";
      4'b1011: return "R5";
      4'b0000: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_all(input logic [3:0] prev_mode);
    string t;
    t = {mode_tag(prev_mode), " R8 R10 R12 R13 pin"};
    chk(t, pin1, m_pin);
    chk({t, " idx0"}, pin0, m_pin);
    chk("R11 oe", oe1, m_oe);
    chk("R11 oe idx0", oe0, m_oe);
    chk("R9 flag", flag1, m_flag);
    chk("R9 flag idx0", flag0, m_flag);
    chk("R5 tmr_rst", trst1, m_trst);
    chk("R5 tmr_rst idx0", trst0, m_trst);
    chk("R5 adc idx1", adc1, m_trst);
    chk("R5 adc idx0", adc0, 1'b0);
  endtask

  // advance the model across one edge using current inputs
  task automatic model_step();
    logic [TW-1:0] t;
    logic eq, entry, cm, hit;
    t = tmr_sel ? tmr_b : tmr_a;
    eq = (t == cmp_val);
    entry = (mode != m_mode_q);
    cm = (mode == 4'b0010) || (mode == 4'b1000) || (mode == 4'b1001) ||
         (mode == 4'b1010) || (mode == 4'b1011);
    hit = eq && !m_eqq && !entry && cm;
    if (mode == 4'b0000) m_pin = 1'b0;
    else if (entry) m_pin = (mode == 4'b1001);
    else if (hit) begin
      if (mode == 4'b0010) m_pin = ~m_pin;
      else if (mode == 4'b1000) m_pin = 1'b1;
      else if (mode == 4'b1001) m_pin = 1'b0;
    end
    m_oe = (mode == 4'b0010) || (mode == 4'b1000) || (mode == 4'b1001) || (mode == 4'b1011);
    if (mode == 4'b0000) m_flag = 1'b0;
    else if (hit) m_flag = 1'b1;
    else if (flag_clr) m_flag = 1'b0;
    m_trst = hit && (mode == 4'b1011);
    m_eqq = eq;
    m_mode_q = mode;
  endtask

  initial begin
    int cyc;
    logic [3:0] pm;
    cyc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mode_q = 4'd0; m_eqq = 0; m_pin = 0; m_oe = 0; m_flag = 0; m_trst = 0;
    check_all(4'd0); // R6 reset state
    for (int md = 0; md < 16; md++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int k = 0; k < 60; k++) begin
          pm = mode;
          mode = md[3:0];
          tmr_sel = sel[0];
          cmp_val = 16'd5 + 16'(sel);
          if ((cyc % 5) != 0) tmr_a = (tmr_a + 16'd1) % 16'd11;
          tmr_b = (tmr_b + 16'd3) % 16'd13;
          flag_clr = ((cyc % 9) == 0);
          model_step();
          cyc++;
          @(negedge clk);
          check_all(mode);
        end
      end
    end
    // R6: return to disabled mode clears everything
    mode = 4'b0000;
    flag_clr = 1'b0;
    model_step();
    @(negedge clk);
    check_all(4'b0000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule